// File: doc/BRIEF.md
# Per-Peripheral Compartment Semaphore Bank

This block holds one hardware semaphore for each protected peripheral slot. Bus masters carry a compartment identifier (CID) on every access. A master uses the bank to take exclusive ownership of a peripheral before it uses that peripheral, and to give ownership back when it is finished. Each slot has two registers. The settings word enables semaphore mode, enables CID filtering and holds an 8-bit allow-list with one bit per CID. The lock register shows whether the semaphore is taken and which CID holds it.

A claim is a write of 1 to the lock flag. The bank accepts it only when the lock is free, semaphore mode is on for that slot and the requester's CID is in the allow-list. After a claim, the requester reads the lock register back and checks that the flag is set and that the owner field holds its own CID. Only the owner can release the lock, by writing 0. Writes from any other CID do not change the lock. Reads return data one cycle after the request. Addresses outside the slot window, and addresses that are not word-aligned, read as zero and ignore writes.

Top module: `cid_sem_bank`

## Requirements
- R1: After reset every lock flag and owner field is 0, and every settings word is 0.
- R2: The lock register reads bit 0 as the lock flag (1 = taken) and bits 6:4 as the owner CID. All other bits read 0, and a free lock reads 0x0.
- R3: The settings word stores bit 0 (CID-filter enable), bit 1 (semaphore-mode enable) and bits 23:16 (allow-list, bit 16+k for CID k). It reads these back, and all other bits read 0.
- R4: The settings word of slot n sits at byte address 0x100 + 8*n and the lock register at 0x104 + 8*n, for n from 0 to 177. Any other address, including one with bits 1:0 not zero, reads 0 and ignores writes.
- R5: A write with data bit 0 = 1 to a free lock succeeds when semaphore mode is on and the requester's allow-list bit is set. The lock then becomes 1 and the owner becomes the requester's CID.
- R6: A write of 1 to a free lock is ignored when semaphore mode is off or the requester's allow-list bit is clear.
- R7: While a lock is held, writes of 0 or 1 from any CID other than the owner leave the lock and the owner unchanged.
- R8: A write of 0 from the owner frees the lock and clears the owner field. After that, another allowed CID can claim the lock.
- R9: Every read request gets exactly one response, valid in the cycle after the request. The response valid signal is low in every other cycle.
- R10: A write of 1 from the current owner leaves the lock held and the owner unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte address |
| reqWdata | input | 32 | Write data |
| reqCid | input | 3 | Requester's compartment ID |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |

## Verification
The assertions assume that each request is complete within one cycle: the request signals hold steady around the rising edge, and there is no request while reset is asserted. The assertions on the lock only look at the slot that the decoder selects. The bench therefore drives each request for exactly one clock between two falling edges and leaves an idle cycle after each one. It sends no traffic during reset and starts driving only after reset is released.

// File: rtl/cid_sem_pkg.sv
package cid_sem_pkg;
  localparam int CID_W   = 3;
  localparam int ALLOW_W = 1 << CID_W;
  localparam int DATA_W  = 32;
  // Bit positions inside the two per-slot registers
  localparam int LOCK_BIT  = 0;
  localparam int OWNER_LSB = 4;
  localparam int FILT_BIT  = 0;
  localparam int MODE_BIT  = 1;
  localparam int ALLOW_LSB = 16;

  typedef struct packed {
    logic setWr;
    logic lockSet;
    logic lockClr;
    logic rdSet;
    logic rdLock;
    logic rdMiss;
  } strobe_t;
endpackage

// File: rtl/cid_sem_ctrl.sv
module cid_sem_ctrl
  import cid_sem_pkg::*;
#(
  parameter int NUM_SLOTS = 178,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h100,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wBit0,
  output strobe_t           strb,
  output logic [SLOT_W-1:0] slotIdx
);
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] BASE  = (ADDR_W)'(BASE_ADDR);
  localparam logic [IDX_W-1:0]  LIMIT = (IDX_W)'(NUM_SLOTS);

  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  rawIdx;
  logic              inWindow;
  logic              isLock;

  always_comb begin
    offset   = reqAddr - BASE;
    rawIdx   = offset[ADDR_W-1:3];
    isLock   = offset[2];
    inWindow = (reqAddr >= BASE) && (offset[1:0] == 2'b00) && (rawIdx < LIMIT);
    slotIdx  = rawIdx[SLOT_W-1:0];
  end

  always_comb begin
    strb         = '0;
    if (reqValid) begin
      if (reqWrite) begin
        strb.setWr   = inWindow && !isLock;
        strb.lockSet = inWindow && isLock && wBit0;
        strb.lockClr = inWindow && isLock && !wBit0;
      end else begin
        strb.rdSet  = inWindow && !isLock;
        strb.rdLock = inWindow && isLock;
        strb.rdMiss = !inWindow;
      end
    end
  end

  // R4: at most one action is decoded for any access
  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setWr, strb.lockSet, strb.lockClr, strb.rdSet, strb.rdLock, strb.rdMiss}));

  // R9: every read request is decoded into exactly one read strobe
  assert_read_decoded_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |-> (strb.rdSet || strb.rdLock || strb.rdMiss));
endmodule

// File: rtl/cid_sem_datapath.sv
module cid_sem_datapath
  import cid_sem_pkg::*;
#(
  parameter int NUM_SLOTS = 178,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic [CID_W-1:0]  cidIn,
  input  logic [DATA_W-1:0] wdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [NUM_SLOTS-1:0]  lockQ;
  logic [CID_W-1:0]      ownerQ [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]  filtQ;
  logic [NUM_SLOTS-1:0]  modeQ;
  logic [ALLOW_W-1:0]    allowQ [NUM_SLOTS];

  logic [NUM_SLOTS-1:0]  selVec;
  logic [NUM_SLOTS-1:0]  grantVec;
  logic [NUM_SLOTS-1:0]  freeVec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    assign selVec[i]   = (slotIdx == SLOT_W'(i));
    assign grantVec[i] = strb.lockSet && selVec[i] && !lockQ[i] && modeQ[i] && allowQ[i][cidIn];
    assign freeVec[i]  = strb.lockClr && selVec[i] && lockQ[i] && (ownerQ[i] == cidIn);

    // R2: a free lock never shows an owner
    assert_free_no_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
      !lockQ[i] |-> (ownerQ[i] == '0));

    // R5, R6: a lock is only taken by an enabled, allowed requester
    assert_take_allowed_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(lockQ[i]) |-> $past(strb.lockSet && selVec[i] && modeQ[i] && allowQ[i][cidIn]));

    // R7, R10: a held lock keeps its owner unless the owner releases it
    assert_owner_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
      (lockQ[i] && !(strb.lockClr && selVec[i] && ownerQ[i] == cidIn))
        |=> (lockQ[i] && $stable(ownerQ[i])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= '0;
      filtQ <= '0;
      modeQ <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        ownerQ[i] <= '0;
        allowQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (strb.setWr && selVec[i]) begin
          filtQ[i]  <= wdata[FILT_BIT];
          modeQ[i]  <= wdata[MODE_BIT];
          allowQ[i] <= wdata[ALLOW_LSB +: ALLOW_W];
        end
        if (grantVec[i]) begin
          lockQ[i]  <= 1'b1;
          ownerQ[i] <= cidIn;
        end else if (freeVec[i]) begin
          lockQ[i]  <= 1'b0;
          ownerQ[i] <= '0;
        end
      end
    end
  end

  logic [DATA_W-1:0] rdNext;

  always_comb begin
    rdNext = '0;
    if (strb.rdLock) begin
      rdNext[LOCK_BIT]             = lockQ[slotIdx];
      rdNext[OWNER_LSB +: CID_W]   = ownerQ[slotIdx];
    end else if (strb.rdSet) begin
      rdNext[FILT_BIT]             = filtQ[slotIdx];
      rdNext[MODE_BIT]             = modeQ[slotIdx];
      rdNext[ALLOW_LSB +: ALLOW_W] = allowQ[slotIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rdSet || strb.rdLock || strb.rdMiss;
      rspData  <= rdNext;
    end
  end

  // R4: a miss read responds with zero data
  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdMiss |=> (rspData == '0));
endmodule

// File: rtl/cid_sem_bank.sv
module cid_sem_bank
  import cid_sem_pkg::*;
#(
  parameter int NUM_SLOTS = 178,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h100,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [2:0]        reqCid,
  output logic              rspValid,
  output logic [31:0]       rspData
);
  strobe_t           strb;
  logic [SLOT_W-1:0] slotIdx;

  cid_sem_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .wBit0(reqWdata[0]), .strb(strb), .slotIdx(slotIdx)
  );

  cid_sem_datapath #(.NUM_SLOTS(NUM_SLOTS)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .slotIdx(slotIdx), .cidIn(reqCid),
    .wdata(reqWdata), .rspValid(rspValid), .rspData(rspData)
  );

  // R9: response exactly one cycle after a read, and never otherwise
  assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);
  assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);
endmodule

// File: tb/test_cid_sem_bank.sv
module test_cid_sem_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [2:0]  reqCid = '0;
  logic        rspValid;
  logic [31:0] rspData;

  int checks = 0;
  int failures = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  cid_sem_bank i_cid_sem_bank (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqCid(reqCid),
    .rspValid(rspValid), .rspData(rspData)
  );

  function automatic logic [11:0] setAddr(int n);
    return 12'(32'h100 + 8 * n);
  endfunction
  function automatic logic [11:0] lockAddr(int n);
    return 12'(32'h104 + 8 * n);
  endfunction

  task automatic doWrite(logic [11:0] a, logic [31:0] d, logic [2:0] c);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d; reqCid = c;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  // Driver: pushes expectation, issues read, checks response timing
  task automatic doRead(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqCid = 3'd0;
    @(negedge clk);
    reqValid = 1'b0;
    checks++;
    if (rspValid !== 1'b1) begin
      failures++;
      $display("FAIL R9 response valid actual=%b expected=1", rspValid);
    end
  endtask

  // Monitor: pops and compares
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 unexpected response actual=1 expected=0");
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (rspData !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, rspData, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    doRead(lockAddr(0),   32'h0, "R1 lock0 after reset");
    doRead(setAddr(0),    32'h0, "R1 settings0 after reset");
    doRead(lockAddr(177), 32'h0, "R1 lock177 after reset");

    // R3 settings layout, stray bits dropped; allow-list CIDs 1 and 2
    doWrite(setAddr(5), 32'hFF06_FFFF, 3'd0);
    doRead(setAddr(5), 32'h0006_0003, "R3 settings readback");

    // R6 CID 3 not allowed
    doWrite(lockAddr(5), 32'h1, 3'd3);
    doRead(lockAddr(5), 32'h0, "R6 claim by non-listed CID");

    // R5 claim by CID 1, R2 owner in bits 6:4
    doWrite(lockAddr(5), 32'h1, 3'd1);
    doRead(lockAddr(5), 32'h11, "R5 R2 claim by CID1");

    // R7 non-owner writes
    doWrite(lockAddr(5), 32'h1, 3'd2);
    doRead(lockAddr(5), 32'h11, "R7 non-owner set");
    doWrite(lockAddr(5), 32'h0, 3'd2);
    doRead(lockAddr(5), 32'h11, "R7 non-owner clear");

    // R10 owner sets again
    doWrite(lockAddr(5), 32'h1, 3'd1);
    doRead(lockAddr(5), 32'h11, "R10 owner re-set");

    // R8 release and reclaim by CID 2
    doWrite(lockAddr(5), 32'h0, 3'd1);
    doRead(lockAddr(5), 32'h0, "R8 owner release");
    doWrite(lockAddr(5), 32'h1, 3'd2);
    doRead(lockAddr(5), 32'h21, "R8 reclaim by CID2");

    // R6 mode off, all CIDs listed
    doWrite(setAddr(7), 32'h00FF_0001, 3'd0);
    doWrite(lockAddr(7), 32'h1, 3'd1);
    doRead(lockAddr(7), 32'h0, "R6 claim with mode off");

    // R4 last slot, CID 7
    doWrite(setAddr(177), 32'h0080_0002, 3'd0);
    doRead(setAddr(177), 32'h0080_0002, "R4 last slot settings");
    doWrite(lockAddr(177), 32'h1, 3'd7);
    doRead(lockAddr(177), 32'h71, "R4 last slot claim");

    // R4 misses: past the end, below base, unaligned
    doWrite(12'h690, 32'hFFFF_FFFF, 3'd0);
    doRead(12'h690, 32'h0, "R4 past-end address");
    doWrite(12'h0FC, 32'hFFFF_FFFF, 3'd0);
    doRead(12'h0FC, 32'h0, "R4 below-base address");
    doWrite(12'h12D, 32'h0, 3'd2);
    doRead(12'h12D, 32'h0, "R4 unaligned read");
    doRead(lockAddr(5), 32'h21, "R4 unaligned write ignored");

    // R1 reset during operation
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doRead(lockAddr(5),   32'h0, "R1 lock5 after reset");
    doRead(setAddr(5),    32'h0, "R1 settings5 after reset");
    doRead(lockAddr(177), 32'h0, "R1 lock177 after reset");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL R9 missing responses actual=%0d expected=0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule